// File: doc/BRIEF.md
# Five-Stage Pipelined RISC Core

A small 32-bit load/store processor organised as a five-stage pipeline: fetch, decode, execute, memory access and write-back, with a register between each pair of stages. It has a separate program memory and data memory. Both are filled through a word-wide preload port, normally while reset is held. After reset is released, the core runs the program from word address zero.

The core executes three-register arithmetic and logic, word loads and stores with a signed 16-bit offset, and an absolute jump. It also has NOP, HALT, and an output instruction that reads a data word and presents it on a strobed 32-bit bus. Jumps and HALT are decided in the fetch stage, so neither one ever occupies a later stage. There is no hazard detection and no forwarding between stages. Programs must place enough NOPs between a producer and its consumer.

Top module: `pcore`

## Requirements
- R1: Every instruction word holds its opcode in bits [31:26], rs in [25:21], rt in [20:16], rd in [15:11], the function code in [5:0] and the signed offset in [15:0]. The opcodes are: three-register 6'h00, load 6'h23, store 6'h2B, jump 6'h02, output 6'h3E, halt 6'h3F.
- R2: A three-register instruction writes rd with rs op rt, using 32-bit wrap-around arithmetic. The function codes are: add 6'h20, subtract 6'h22, AND 6'h24, OR 6'h25.
- R3: A load writes rt with the data word at word address rs plus the sign-extended offset. Only the low DMEM_AW bits of that sum are used.
- R4: A store writes rt into data memory at word address rs plus the sign-extended offset, and leaves every register unchanged.
- R5: Register 0 always reads as zero, even after an instruction names it as a destination.
- R6: A jump loads the program counter with the low IMEM_AW bits of its 26-bit target. The word that follows the jump is never executed, and the jump itself never leaves the fetch stage.
- R7: The all-zero word is a NOP. It passes through every stage and changes no register, no memory word and no output.
- R8: When HALT is fetched, halted rises at the next clock edge and pcNow stays at the address of the HALT. Instructions fetched earlier complete; nothing after the HALT executes. All state stays frozen until reset.
- R9: An output instruction reads the data word at rs plus the sign-extended offset in the memory stage and puts it on outBus, with outValid high for exactly one cycle. It also writes that word into rt. outBus holds its value between strobes.
- R10: A result written back is visible to an instruction fetched three slots later: the register file writes before it reads within one cycle.
- R11: Reset clears the program counter, every pipeline register, the register file, the halted flag, outValid and outBus.
- R12: When ldEn is high at a clock edge, ldData is written at ldAddr. With ldSel = 0 the write goes to program memory; with ldSel = 1 it goes to data memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| ldEn | input | 1 | Preload write enable |
| ldSel | input | 1 | Preload target: 0 program memory, 1 data memory |
| ldAddr | input | max(IMEM_AW, DMEM_AW) | Preload word address |
| ldData | input | 32 | Preload word |
| outBus | output | 32 | Word produced by the last output instruction |
| outValid | output | 1 | One-cycle strobe marking a new outBus word |
| halted | output | 1 | High once a HALT has been fetched |
| pcNow | output | IMEM_AW | Current program counter, as a word address |

## Verification
The properties assume that a load or store never appears in the data-memory preload port's cycle. They also assume that program memory is rewritten only while reset holds the core idle; otherwise the fetch-stage jump and halt decode would see a changing word. They further assume that a dependent instruction sits at least three slots behind its producer. The stimulus keeps to all three assumptions. Every program and data word is loaded with rstN low, and every test program pads producers and consumers with NOPs to exactly the minimum three-slot distance. That padding also exercises the same-cycle write-then-read path of the register file.

// File: rtl/pcore_pkg.sv
package pcore_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_OUT   = 6'h3E;
  localparam logic [5:0] OP_HALT  = 6'h3F;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [2:0] {ALU_ZERO, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  // strobes carried from decode into execute
  typedef struct packed {
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    outEn;
    logic    useImm;
    alu_op_e aluOp;
  } ex_ctrl_t;

  // full decode result; dstRt is consumed in decode itself
  typedef struct packed {
    logic     dstRt;
    ex_ctrl_t ex;
  } ctrl_t;
endpackage

// File: rtl/pcore_fetch.sv
module pcore_fetch
  import pcore_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldEn,
  input  logic               ldSel,
  input  logic [IMEM_AW-1:0] ldAddr,
  input  logic [XLEN-1:0]    ldData,
  output logic [XLEN-1:0]    ifIdInstr,
  output logic [IMEM_AW-1:0] pcOut,
  output logic               haltedOut,
  output logic               jumpTaken
);
  localparam int IMEM_DEPTH = 1 << IMEM_AW;

  logic [XLEN-1:0]    progMem [IMEM_DEPTH];
  logic [IMEM_AW-1:0] pcQ;
  logic               haltQ;
  logic [XLEN-1:0]    instrQ;
  logic [XLEN-1:0]    fetched;
  logic               haltSeen;

  assign fetched   = progMem[pcQ];
  assign jumpTaken = !haltQ && (fetched[31:26] == OP_JUMP);
  assign haltSeen  = !haltQ && (fetched[31:26] == OP_HALT);

  always_ff @(posedge clk) begin
    if (ldEn && !ldSel) progMem[ldAddr] <= ldData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= '0;
      haltQ  <= 1'b0;
      instrQ <= '0;
    end else if (haltSeen) begin
      haltQ  <= 1'b1;
      instrQ <= '0;
    end else if (jumpTaken) begin
      pcQ    <= fetched[IMEM_AW-1:0];
      instrQ <= '0;
    end else if (!haltQ) begin
      pcQ    <= pcQ + 1'b1;
      instrQ <= fetched;
    end
  end

  assign ifIdInstr = instrQ;
  assign pcOut     = pcQ;
  assign haltedOut = haltQ;
endmodule

// File: rtl/pcore_ctrl.sv
module pcore_ctrl
  import pcore_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_RTYPE: begin
        if (instr != '0) begin
          ctrl.ex.regWrite = 1'b1;
          case (funct)
            FN_ADD:  ctrl.ex.aluOp = ALU_ADD;
            FN_SUB:  ctrl.ex.aluOp = ALU_SUB;
            FN_AND:  ctrl.ex.aluOp = ALU_AND;
            FN_OR:   ctrl.ex.aluOp = ALU_OR;
            default: ctrl.ex.aluOp = ALU_ZERO;
          endcase
        end
      end
      OP_LOAD: begin
        ctrl.ex.regWrite = 1'b1;
        ctrl.ex.memRead  = 1'b1;
        ctrl.ex.useImm   = 1'b1;
        ctrl.ex.aluOp    = ALU_ADD;
        ctrl.dstRt       = 1'b1;
      end
      OP_STORE: begin
        ctrl.ex.memWrite = 1'b1;
        ctrl.ex.useImm   = 1'b1;
        ctrl.ex.aluOp    = ALU_ADD;
      end
      OP_OUT: begin
        ctrl.ex.regWrite = 1'b1;
        ctrl.ex.memRead  = 1'b1;
        ctrl.ex.outEn    = 1'b1;
        ctrl.ex.useImm   = 1'b1;
        ctrl.ex.aluOp    = ALU_ADD;
        ctrl.dstRt       = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/pcore_dpath.sv
module pcore_dpath
  import pcore_pkg::*;
#(
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [25:0]        instr,
  input  ctrl_t              ctrl,
  input  logic               ldEn,
  input  logic               ldSel,
  input  logic [DMEM_AW-1:0] ldAddr,
  input  logic [XLEN-1:0]    ldData,
  output logic [XLEN-1:0]    outBus,
  output logic               outValid,
  output logic               exMemStoreO,
  output logic               memWbRegWriteO
);
  localparam int DMEM_DEPTH = 1 << DMEM_AW;
  localparam int RIDX_W     = $clog2(NREG);

  // decode
  logic [RIDX_W-1:0] rsIdx, rtIdx, dstIdx;
  logic [XLEN-1:0]   immExt, rsVal, rtVal;
  // decode -> execute
  ex_ctrl_t          idExCtrl;
  logic [XLEN-1:0]   idExA, idExB, idExImm;
  logic [RIDX_W-1:0] idExDst;
  // execute -> memory
  logic [XLEN-1:0]   aluB, aluOut;
  logic              exMemRegWrite, exMemMemRead, exMemMemWrite, exMemOutEn;
  logic [XLEN-1:0]   exMemAlu, exMemStore;
  logic [RIDX_W-1:0] exMemDst;
  // memory -> write-back
  logic [XLEN-1:0]   dataMem [DMEM_DEPTH];
  logic [XLEN-1:0]   memWord;
  logic              memWbRegWrite;
  logic [XLEN-1:0]   memWbData;
  logic [RIDX_W-1:0] memWbDst;
  // register file
  logic [XLEN-1:0]   regs [NREG];
  logic              wbWe;

  assign wbWe = memWbRegWrite && (memWbDst != '0);

  function automatic logic [XLEN-1:0] readReg(input logic [RIDX_W-1:0] idx,
                                              input logic we,
                                              input logic [RIDX_W-1:0] wIdx,
                                              input logic [XLEN-1:0] wData,
                                              input logic [XLEN-1:0] stored);
    if (idx == '0) return '0;
    if (we && (wIdx == idx)) return wData;
    return stored;
  endfunction

  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign dstIdx = ctrl.dstRt ? instr[20:16] : instr[15:11];
  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign rsVal  = readReg(rsIdx, wbWe, memWbDst, memWbData, regs[rsIdx]);
  assign rtVal  = readReg(rtIdx, wbWe, memWbDst, memWbData, regs[rtIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idExCtrl <= '0;
      idExA    <= '0;
      idExB    <= '0;
      idExImm  <= '0;
      idExDst  <= '0;
    end else begin
      idExCtrl <= ctrl.ex;
      idExA    <= rsVal;
      idExB    <= rtVal;
      idExImm  <= immExt;
      idExDst  <= dstIdx;
    end
  end

  assign aluB = idExCtrl.useImm ? idExImm : idExB;

  always_comb begin
    case (idExCtrl.aluOp)
      ALU_ADD: aluOut = idExA + aluB;
      ALU_SUB: aluOut = idExA - aluB;
      ALU_AND: aluOut = idExA & aluB;
      ALU_OR:  aluOut = idExA | aluB;
      default: aluOut = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exMemRegWrite <= 1'b0;
      exMemMemRead  <= 1'b0;
      exMemMemWrite <= 1'b0;
      exMemOutEn    <= 1'b0;
      exMemAlu      <= '0;
      exMemStore    <= '0;
      exMemDst      <= '0;
    end else begin
      exMemRegWrite <= idExCtrl.regWrite;
      exMemMemRead  <= idExCtrl.memRead;
      exMemMemWrite <= idExCtrl.memWrite;
      exMemOutEn    <= idExCtrl.outEn;
      exMemAlu      <= aluOut;
      exMemStore    <= idExB;
      exMemDst      <= idExDst;
    end
  end

  assign memWord = dataMem[exMemAlu[DMEM_AW-1:0]];

  always_ff @(posedge clk) begin
    if (ldEn && ldSel)      dataMem[ldAddr] <= ldData;
    else if (exMemMemWrite) dataMem[exMemAlu[DMEM_AW-1:0]] <= exMemStore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWbRegWrite <= 1'b0;
      memWbData     <= '0;
      memWbDst      <= '0;
      outValid      <= 1'b0;
      outBus        <= '0;
    end else begin
      memWbRegWrite <= exMemRegWrite;
      memWbData     <= exMemMemRead ? memWord : exMemAlu;
      memWbDst      <= exMemDst;
      outValid      <= exMemOutEn;
      if (exMemOutEn) outBus <= memWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wbWe) begin
      regs[memWbDst] <= memWbData;
    end
  end

  assign exMemStoreO    = exMemMemWrite;
  assign memWbRegWriteO = memWbRegWrite;
endmodule

// File: rtl/pcore.sv
module pcore
  import pcore_pkg::*;
#(
  parameter  int IMEM_AW = 6,
  parameter  int DMEM_AW = 6,
  localparam int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldEn,
  input  logic               ldSel,
  input  logic [LD_AW-1:0]   ldAddr,
  input  logic [31:0]        ldData,
  output logic [31:0]        outBus,
  output logic               outValid,
  output logic               halted,
  output logic [IMEM_AW-1:0] pcNow
);
  logic [XLEN-1:0] ifIdInstr;
  logic            jumpTaken;
  ctrl_t           decCtrl;
  logic            exMemStore;
  logic            memWbRegWrite;

  pcore_fetch #(.IMEM_AW(IMEM_AW)) u_fetch (
    .clk       (clk),
    .rstN      (rstN),
    .ldEn      (ldEn),
    .ldSel     (ldSel),
    .ldAddr    (ldAddr[IMEM_AW-1:0]),
    .ldData    (ldData),
    .ifIdInstr (ifIdInstr),
    .pcOut     (pcNow),
    .haltedOut (halted),
    .jumpTaken (jumpTaken)
  );

  pcore_ctrl u_ctrl (
    .instr (ifIdInstr),
    .ctrl  (decCtrl)
  );

  pcore_dpath #(.DMEM_AW(DMEM_AW)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .instr          (ifIdInstr[25:0]),
    .ctrl           (decCtrl),
    .ldEn           (ldEn),
    .ldSel          (ldSel),
    .ldAddr         (ldAddr[DMEM_AW-1:0]),
    .ldData         (ldData),
    .outBus         (outBus),
    .outValid       (outValid),
    .exMemStoreO    (exMemStore),
    .memWbRegWriteO (memWbRegWrite)
  );
endmodule

// File: rtl/pcore_checker.sv
module pcore_checker #(
  parameter int PC_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            halted,
  input logic [PC_W-1:0] pcNow,
  input logic            outValid,
  input logic [31:0]     outBus,
  input logic [31:0]     ifIdInstr,
  input logic            jumpTaken,
  input logic            exMemStore,
  input logic            memWbRegWrite
);
  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pcNow)));

  a_r8_halt_no_issue: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (ifIdInstr == 32'd0));

  a_r6_jump_stays_in_fetch: assert property (@(posedge clk) disable iff (!rstN)
    jumpTaken |=> (ifIdInstr == 32'd0));

  a_r4_store_no_writeback: assert property (@(posedge clk) disable iff (!rstN)
    exMemStore |=> !memWbRegWrite);

  a_r9_out_bus_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outBus) |-> outValid);

  always @(posedge clk) begin
    if (!rstN) begin
      a_r11_reset_state: assert (pcNow == '0 && !halted && !outValid && outBus == 32'd0);
    end
  end
endmodule

bind pcore pcore_checker #(.PC_W(IMEM_AW)) u_pcore_checker (
  .clk           (clk),
  .rstN          (rstN),
  .halted        (halted),
  .pcNow         (pcNow),
  .outValid      (outValid),
  .outBus        (outBus),
  .ifIdInstr     (ifIdInstr),
  .jumpTaken     (jumpTaken),
  .exMemStore    (exMemStore),
  .memWbRegWrite (memWbRegWrite)
);

// File: tb/pcore_bench.sv
module pcore_bench;
  localparam int AW = 6;
  localparam int NWORDS = 1 << AW;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [5:0]  fn;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{a: 32'd5,          b: 32'd7,          fn: 6'h20, exp: 32'h0000_000C},
    '{a: 32'hFFFF_FFFF,  b: 32'd2,          fn: 6'h20, exp: 32'h0000_0001},
    '{a: 32'd3,          b: 32'd10,         fn: 6'h22, exp: 32'hFFFF_FFF9},
    '{a: 32'h8000_0000,  b: 32'd1,          fn: 6'h22, exp: 32'h7FFF_FFFF},
    '{a: 32'hF0F0_1234,  b: 32'h0FF0_FFFF,  fn: 6'h24, exp: 32'h00F0_1234},
    '{a: 32'hA000_0005,  b: 32'h0500_0030,  fn: 6'h25, exp: 32'hA500_0035},
    '{a: 32'hFFFF_FFFF,  b: 32'd0,          fn: 6'h24, exp: 32'h0000_0000},
    '{a: 32'd0,          b: 32'h1234_5678,  fn: 6'h25, exp: 32'h1234_5678}
  };

  localparam logic [31:0] W_NOP  = 32'h0000_0000;
  localparam logic [31:0] W_HALT = 32'hFC00_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0;
  logic        ldSel = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic [31:0] ldData = '0;
  logic [31:0] outBus;
  logic        outValid;
  logic        halted;
  logic [AW-1:0] pcNow;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int outCount = 0;
  logic [31:0] outLog [8];
  logic [31:0] progImg [NWORDS];

  always #10 clk = ~clk;

  pcore u_pcore (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldSel(ldSel), .ldAddr(ldAddr),
    .ldData(ldData), .outBus(outBus), .outValid(outValid), .halted(halted),
    .pcNow(pcNow)
  );

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (outCount < 8) outLog[outCount] = outBus;
      outCount++;
    end
  end

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] encJ(int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < NWORDS; i++) progImg[i] = W_NOP;
  endtask

  task automatic loadWord(logic sel, int addr, logic [31:0] data);
    @(negedge clk);
    ldEn = 1'b1; ldSel = sel; ldAddr = AW'(addr); ldData = data;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // holds reset, loads the program image; data words follow via loadWord
  task automatic enterLoad();
    @(negedge clk);
    rstN = 1'b0;
    outCount = 0;
    for (int i = 0; i < NWORDS; i++) loadWord(1'b0, i, progImg[i]);
  endtask

  task automatic runToHalt();
    int cyc;
    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    while (!halted && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    // R11: state while reset is held
    repeat (2) @(negedge clk);
    check("R11 reset pcNow", 32'(pcNow), 32'd0);
    check("R11 reset halted", 32'(halted), 32'd0);
    check("R11 reset outValid", 32'(outValid), 32'd0);
    check("R11 reset outBus", outBus, 32'd0);

    // R1/R2/R3/R10/R12: table of ALU vectors, consumer exactly three slots after producer
    for (int v = 0; v < NVEC; v++) begin
      clearProg();
      progImg[0] = encI(6'h23, 0, 1, 16'd0);
      progImg[1] = encI(6'h23, 0, 2, 16'd1);
      progImg[4] = encR(1, 2, 3, VECS[v].fn);
      progImg[7] = encI(6'h2B, 0, 3, 16'd2);
      progImg[8] = encI(6'h3E, 0, 4, 16'd2);
      progImg[9] = W_HALT;
      enterLoad();
      loadWord(1'b1, 0, VECS[v].a);
      loadWord(1'b1, 1, VECS[v].b);
      loadWord(1'b1, 2, 32'hDEAD_BEEF);
      runToHalt();
      check($sformatf("R2/R10/R12 vector %0d result", v), outLog[0], VECS[v].exp);
      check($sformatf("R9 vector %0d strobe count", v), 32'(outCount), 32'd1);
    end

    // R6/R7: jump skips the next word; NOP run between changes nothing
    clearProg();
    progImg[0] = encJ(6);
    progImg[1] = encI(6'h3E, 0, 1, 16'd3);
    progImg[6] = encI(6'h3E, 0, 1, 16'd4);
    progImg[7] = W_HALT;
    enterLoad();
    loadWord(1'b1, 3, 32'h3333_3333);
    loadWord(1'b1, 4, 32'h4444_0004);
    runToHalt();
    check("R6 only jump target output seen", 32'(outCount), 32'd1);
    check("R6 jump target data", outLog[0], 32'h4444_0004);
    check("R8 pc holds at HALT after jump", 32'(pcNow), 32'd7);

    // R8: HALT first, following output never executes, state frozen
    clearProg();
    progImg[0] = W_HALT;
    progImg[1] = encI(6'h3E, 0, 1, 16'd4);
    enterLoad();
    loadWord(1'b1, 4, 32'h5555_0000);
    runToHalt();
    check("R8 halted flag", 32'(halted), 32'd1);
    check("R8 nothing after HALT", 32'(outCount), 32'd0);
    repeat (20) @(negedge clk);
    check("R8 pc frozen", 32'(pcNow), 32'd0);

    // R3/R4/R5/R9/R7: negative offset, register 0, store writes no register
    clearProg();
    progImg[0]  = encI(6'h23, 0, 1, 16'd0);
    progImg[1]  = encI(6'h23, 0, 0, 16'd1);
    progImg[2]  = encI(6'h23, 0, 5, 16'd1);
    progImg[4]  = encI(6'h23, 1, 2, 16'hFFFD);
    progImg[5]  = encI(6'h2B, 1, 5, 16'd3);
    progImg[6]  = encI(6'h2B, 0, 0, 16'd20);
    progImg[7]  = encI(6'h2B, 0, 2, 16'd21);
    progImg[8]  = encI(6'h2B, 0, 5, 16'd22);
    progImg[9]  = encI(6'h3E, 0, 6, 16'd20);
    progImg[10] = encI(6'h3E, 0, 7, 16'd21);
    progImg[11] = encI(6'h3E, 0, 6, 16'd22);
    progImg[12] = encI(6'h3E, 0, 6, 16'd13);
    progImg[13] = encI(6'h2B, 0, 7, 16'd23);
    progImg[14] = encI(6'h3E, 0, 8, 16'd23);
    progImg[15] = W_HALT;
    enterLoad();
    loadWord(1'b1, 0, 32'd10);
    loadWord(1'b1, 1, 32'h55AA_55AA);
    loadWord(1'b1, 7, 32'h7777_0707);
    loadWord(1'b1, 13, 32'hBAD0_0013);
    loadWord(1'b1, 20, 32'hBAD0_0020);
    loadWord(1'b1, 21, 32'hBAD0_0021);
    loadWord(1'b1, 22, 32'hBAD0_0022);
    loadWord(1'b1, 23, 32'hBAD0_0023);
    runToHalt();
    check("R9 one strobe cycle per output", 32'(outCount), 32'd5);
    check("R5 register 0 stays zero", outLog[0], 32'd0);
    check("R3 negative offset load", outLog[1], 32'h7777_0707);
    check("R4 store left source register intact", outLog[2], 32'h55AA_55AA);
    check("R4 store at base plus offset", outLog[3], 32'h55AA_55AA);
    check("R9 output writes rt", outLog[4], 32'h7777_0707);

    // R11: reset in a halted, non-empty state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 reset clears halted", 32'(halted), 32'd0);
    check("R11 reset clears outBus", outBus, 32'd0);
    check("R11 reset clears pc", 32'(pcNow), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end
endmodule